// File: doc/BRIEF.md
# Scanned Key Matrix and Multiplexed Display Controller

This block walks a shared set of scan lines across a key matrix and a multiplexed display at the same time. A programmable prescaler turns the system clock into a slow scan tick (around 100 kHz in a real system). On every tick the scan count advances. The row that the count points at is read back through eight return lines, and the display digit with the same index is driven from a 16-byte display memory.

A key enters an eight-entry queue only when it reads closed on two consecutive visits of its row. Each queued byte holds the key position together with the shift and control inputs at the moment the key was taken. Two arbitration policies are available: a lockout policy that takes only the first of several keys held together, and a rollover policy that queues every key. The interrupt line is high while the queue holds anything.

A processor reaches the block through chip select, read, write and one address bit. With the address bit at 0 it reads key codes or display bytes, or writes display bytes. With the address bit at 1 it writes commands or reads status. The command opcode sits in data bits 7:5: 000 mode (bit 0 = rollover, bit 1 = decoded scan), 001 prescale (bits 4:0 = N), 010 read source is the queue, 011 read source is display memory with the pointer at bits 3:0, 100 set the write pointer to bits 3:0, 101 blank (bit 0), 110 clear overrun.

Top module: `keymat_display_ctrl`

## Requirements
- R1: After reset the block uses encoded scan, lockout, an unblanked display and a read source of the queue. The scan output is 0, the interrupt is low and status reads 0x00.
- R2: In encoded mode the scan output counts 0 to 15 in binary. In decoded mode it cycles 0001, 0010, 0100, 1000. Both advance once per scan tick.
- R3: A closure seen on only one visit of its row queues nothing.
- R4: A queued byte is {control, shift, row[2:0], column[2:0]}, with shift and control taken when the key is accepted. In encoded mode the row equals the scan count 0 to 7; counts 8 to 15 read no keys. In decoded mode the row is the index of the active scan line.
- R5: The queue holds 8 bytes and returns them in arrival order. Each data read with the queue as source removes one byte.
- R6: The interrupt output is high exactly when the queue was non-empty one clock earlier.
- R7: A key accepted while the queue is full is dropped and sets overrun. Status is {overrun, 3'b000, count[3:0]}, and the clear-overrun command resets the flag.
- R8: In lockout mode no new key is taken while an accepted key is still held. Among new keys in one row, only the lowest column is taken. A blocked key that is still held is taken once the first key is released.
- R9: In rollover mode every held key is queued, one per row visit and lowest column first.
- R10: Data writes store into display memory at the pointer, and data reads with the display as source return from the pointer. The pointer advances by one after each such access. Group A shows bits 7:4 and group B shows bits 3:0 of the byte indexed by the current scan count.
- R11: While blank is set, both display groups are 0.
- R12: A key that stays held produces one queue entry only.
- R13: With prescale N the scan output changes every N+1 clocks (N at least 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe, one access per cycle |
| wr | input | 1 | Write strobe, one access per cycle |
| a0 | input | 1 | 0 = data, 1 = command/status |
| din | input | 8 | Write data |
| dout | output | 8 | Registered read data |
| irq | output | 1 | Queue-not-empty interrupt |
| ret_in | input | 8 | Return lines, 1 = key closed |
| shift_in | input | 1 | Shift key state |
| ctrl_in | input | 1 | Control key state |
| scan_out | output | 4 | Shared scan lines |
| grp_a | output | 4 | Display group A (high nibble) |
| grp_b | output | 4 | Display group B (low nibble) |

## Verification
The key logic is driven with one isolated key held for many frames, a pulse that lasts a single row visit, two keys in different rows pressed one after the other, two keys sharing a row pressed in the same instant, and a flood of nine held keys. Together these separate debounce from repeat suppression, lockout from rollover, the column-order rule from the row-order rule, and a normal push from an overflow drop. A table of display bytes is written, read back and observed on the groups at matching scan counts, which checks both the pointer increment and the nibble split. The scan sequence is compared in both encodings and at two prescale values.

// File: rtl/kd_pkg.sv
package kd_pkg;
  typedef enum logic [2:0] {
    OP_MODE     = 3'd0,
    OP_PRESCALE = 3'd1,
    OP_RD_FIFO  = 3'd2,
    OP_RD_DISP  = 3'd3,
    OP_WR_DISP  = 3'd4,
    OP_BLANK    = 3'd5,
    OP_CLR_OVR  = 3'd6,
    OP_NONE     = 3'd7
  } kd_op_e;
endpackage

// File: rtl/kd_prescaler.sv
module kd_prescaler #(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/kd_scan_ctr.sv
module kd_scan_ctr #(
  parameter int NSCAN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             decoded,
  output logic [NSCAN-1:0] cnt,
  output logic [NSCAN-1:0] scan_q
);
  localparam int SEL_W = $clog2(NSCAN);
  localparam logic [NSCAN-1:0] DEC_LAST = NSCAN'(NSCAN - 1);
  localparam logic [NSCAN-1:0] ENC_LAST = '1;

  logic [NSCAN-1:0] last;
  assign last = decoded ? DEC_LAST : ENC_LAST;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      scan_q <= '0;
    end else begin
      if (tick) cnt <= (cnt >= last) ? '0 : cnt + 1'b1;
      scan_q <= decoded ? (NSCAN'(1) << cnt[SEL_W-1:0]) : cnt;
    end
  end
endmodule

// File: rtl/kd_keyscan.sv
module kd_keyscan #(
  parameter int NRET  = 8,
  parameter int ROW_W = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      tick,
  input  logic                      row_valid,
  input  logic [ROW_W-1:0]          row,
  input  logic [NRET-1:0]           ret,
  input  logic                      rollover,
  input  logic                      shift_in,
  input  logic                      ctrl_in,
  output logic                      push,
  output logic [1+1+ROW_W+$clog2(NRET)-1:0] code
);
  localparam int COL_W = $clog2(NRET);
  localparam int NROW  = 2 ** ROW_W;

  logic [NRET-1:0]  prev [NROW];
  logic [NRET-1:0]  acc  [NROW];
  logic [NRET-1:0]  cand;
  logic [COL_W-1:0] col;
  logic             hit, any_held, take;

  always_comb begin
    cand = ret & prev[row] & ~acc[row];
    hit  = 1'b0;
    col  = '0;
    for (int i = NRET - 1; i >= 0; i--) begin
      if (cand[i]) begin
        hit = 1'b1;
        col = i[COL_W-1:0];
      end
    end
    any_held = 1'b0;
    for (int r = 0; r < NROW; r++) any_held = any_held | (|acc[r]);
    take = hit && (rollover || !any_held);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NROW; r++) begin
        prev[r] <= '0;
        acc[r]  <= '0;
      end
      push <= 1'b0;
      code <= '0;
    end else begin
      push <= 1'b0;
      if (tick && row_valid) begin
        prev[row] <= ret;
        acc[row]  <= (acc[row] | (take ? (NRET'(1) << col) : '0)) & ret;
        push      <= take;
        code      <= {ctrl_in, shift_in, row, col};
      end
    end
  end
endmodule

// File: rtl/kd_fifo.sv
module kd_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  input  logic                       clr_ovr,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       ovr
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          full, do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && (count != '0);
  assign head    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      ovr   <= 1'b0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
      if (push && full) ovr <= 1'b1;
      else if (clr_ovr) ovr <= 1'b0;
    end
  end
endmodule

// File: rtl/keymat_display_ctrl.sv
module keymat_display_ctrl
  import kd_pkg::*;
#(
  parameter int NRET       = 8,
  parameter int NSCAN      = 4,
  parameter int FIFO_DEPTH = 8,
  parameter int DIV_RESET  = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs,
  input  logic             rd,
  input  logic             wr,
  input  logic             a0,
  input  logic [7:0]       din,
  output logic [7:0]       dout,
  output logic             irq,
  input  logic [NRET-1:0]  ret_in,
  input  logic             shift_in,
  input  logic             ctrl_in,
  output logic [NSCAN-1:0] scan_out,
  output logic [3:0]       grp_a,
  output logic [3:0]       grp_b
);
  localparam int DIV_W      = 5;
  localparam int ROW_W      = NSCAN - 1;
  localparam int CODE_W     = 2 + ROW_W + $clog2(NRET);
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);
  localparam int DISP_DEPTH = 2 ** NSCAN;

  logic             rollover_q, decoded_q, src_disp_q, blank_q;
  logic [DIV_W-1:0] div_q;
  logic [NSCAN-1:0] ptr_q, cnt;
  logic [7:0]       ram [DISP_DEPTH];
  logic             tick, key_push, pop, clr_ovr, ovr, wr_stb, rd_stb;
  logic [CODE_W-1:0] key_code;
  logic [7:0]       head;
  logic [CNT_W-1:0] fifo_count;
  logic [7:0]       status;
  kd_op_e           op;

  assign wr_stb  = cs && wr;
  assign rd_stb  = cs && rd;
  assign op      = kd_op_e'(din[7:5]);
  assign clr_ovr = wr_stb && a0 && (op == OP_CLR_OVR);
  assign pop     = rd_stb && !a0 && !src_disp_q;
  assign status  = {ovr, {(7 - CNT_W){1'b0}}, fifo_count};

  kd_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst(rst), .div(div_q), .tick(tick)
  );

  kd_scan_ctr #(.NSCAN(NSCAN)) u_scan (
    .clk(clk), .rst(rst), .tick(tick), .decoded(decoded_q),
    .cnt(cnt), .scan_q(scan_out)
  );

  kd_keyscan #(.NRET(NRET), .ROW_W(ROW_W)) u_keys (
    .clk(clk), .rst(rst), .tick(tick), .row_valid(!cnt[NSCAN-1]),
    .row(cnt[ROW_W-1:0]), .ret(ret_in), .rollover(rollover_q),
    .shift_in(shift_in), .ctrl_in(ctrl_in), .push(key_push), .code(key_code)
  );

  kd_fifo #(.W(CODE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(key_push), .wdata(key_code), .pop(pop),
    .clr_ovr(clr_ovr), .head(head), .count(fifo_count), .ovr(ovr)
  );

  always_ff @(posedge clk) begin
    if (wr_stb && !a0) ram[ptr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rollover_q <= 1'b0;
      decoded_q  <= 1'b0;
      src_disp_q <= 1'b0;
      blank_q    <= 1'b0;
      div_q      <= DIV_W'(DIV_RESET);
      ptr_q      <= '0;
      dout       <= '0;
      irq        <= 1'b0;
      grp_a      <= '0;
      grp_b      <= '0;
    end else begin
      irq <= (fifo_count != '0);
      if (blank_q) begin
        grp_a <= '0;
        grp_b <= '0;
      end else begin
        grp_a <= ram[cnt][7:4];
        grp_b <= ram[cnt][3:0];
      end
      if (wr_stb && a0) begin
        unique case (op)
          OP_MODE:     begin rollover_q <= din[0]; decoded_q <= din[1]; end
          OP_PRESCALE: div_q <= din[DIV_W-1:0];
          OP_RD_FIFO:  src_disp_q <= 1'b0;
          OP_RD_DISP:  begin src_disp_q <= 1'b1; ptr_q <= din[NSCAN-1:0]; end
          OP_WR_DISP:  ptr_q <= din[NSCAN-1:0];
          OP_BLANK:    blank_q <= din[0];
          default:     ;
        endcase
      end else if (wr_stb) begin
        ptr_q <= ptr_q + 1'b1;
      end else if (rd_stb) begin
        if (a0) dout <= status;
        else if (src_disp_q) begin
          dout  <= ram[ptr_q];
          ptr_q <= ptr_q + 1'b1;
        end else dout <= head;
      end
    end
  end
endmodule

// File: rtl/keymat_display_chk.sv
module keymat_display_chk #(
  parameter int NSCAN = 4,
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       irq,
  input logic [$clog2(DEPTH+1)-1:0] fifo_count,
  input logic                       key_push,
  input logic                       pop,
  input logic                       ovr,
  input logic                       decoded_q,
  input logic                       blank_q,
  input logic                       tick,
  input logic [NSCAN-1:0]           cnt,
  input logic [NSCAN-1:0]           scan_out,
  input logic [3:0]                 grp_a,
  input logic [3:0]                 grp_b
);
  localparam int CW = $clog2(DEPTH + 1);

  p_irq_tracks_r6: assert property (@(posedge clk) disable iff (rst)
    irq == $past(fifo_count != '0));

  p_depth_bound_r5: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= CW'(DEPTH));

  p_full_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (fifo_count == CW'(DEPTH) && key_push && !pop) |=> (fifo_count == CW'(DEPTH) && ovr));

  p_onehot_scan_r2: assert property (@(posedge clk) disable iff (rst)
    $past(decoded_q) |-> $onehot(scan_out));

  p_scan_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));

  p_blank_dark_r11: assert property (@(posedge clk) disable iff (rst)
    $past(blank_q) |-> (grp_a == 4'h0 && grp_b == 4'h0));
endmodule

bind keymat_display_ctrl keymat_display_chk #(.NSCAN(NSCAN), .DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .fifo_count(fifo_count), .key_push(key_push),
  .pop(pop), .ovr(ovr), .decoded_q(decoded_q), .blank_q(blank_q), .tick(tick),
  .cnt(cnt), .scan_out(scan_out), .grp_a(grp_a), .grp_b(grp_b)
);

// File: tb/keymat_display_ctrl_tb.sv
module keymat_display_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs = 0, rd = 0, wr = 0, a0 = 0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       irq;
  logic [7:0] ret_in;
  logic       shift_in = 0, ctrl_in = 0;
  logic [3:0] scan_out, grp_a, grp_b;
  logic [7:0] km [8];
  logic       tb_dec = 1'b0;
  int         checks = 0, fails = 0;

  always #5 clk = ~clk;

  keymat_display_ctrl #(.DIV_RESET(3)) u_dut (
    .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .a0(a0), .din(din),
    .dout(dout), .irq(irq), .ret_in(ret_in), .shift_in(shift_in),
    .ctrl_in(ctrl_in), .scan_out(scan_out), .grp_a(grp_a), .grp_b(grp_b)
  );

  // key matrix model: rows selected by the scan lines
  always_comb begin
    ret_in = '0;
    if (tb_dec) begin
      for (int i = 0; i < 4; i++) if (scan_out[i]) ret_in = ret_in | km[i];
    end else if (!scan_out[3]) begin
      ret_in = km[scan_out[2:0]];
    end
  end

  // address, data
  localparam logic [11:0] DV [8] = '{
    {4'd0, 8'h3C}, {4'd1, 8'hA5}, {4'd2, 8'h0F}, {4'd5, 8'hF0},
    {4'd7, 8'h81}, {4'd10, 8'h5A}, {4'd14, 8'hC3}, {4'd15, 8'h7E}
  };

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic addr, input logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; a0 = addr; din = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic cpu_rd(input logic addr, output logic [7:0] d);
    @(negedge clk); cs = 1; rd = 1; a0 = addr;
    @(negedge clk); cs = 0; rd = 0; d = dout;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scan(input logic [3:0] v);
    do @(negedge clk); while (scan_out != v);
  endtask

  task automatic wait_change(output int n);
    logic [3:0] p;
    p = scan_out; n = 0;
    do begin @(negedge clk); n++; end while (scan_out == p);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] q [8];
    int n;
    for (int i = 0; i < 8; i++) km[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(scan_out == 4'h0, "R1 scan", {4'h0, scan_out}, 8'h00);
    chk(irq == 1'b0, "R1 irq", {7'h0, irq}, 8'h00);
    cpu_rd(1, d);
    chk(d == 8'h00, "R1 status", d, 8'h00);

    // R2 encoded sequence, R13 default period
    wait_scan(4'd0);
    wait_change(n);
    chk(scan_out == 4'd1, "R2 encoded step", {4'h0, scan_out}, 8'h01);
    wait_change(n);
    chk(scan_out == 4'd2, "R2 encoded step", {4'h0, scan_out}, 8'h02);
    chk(n == 4, "R13 period div3", n[7:0], 8'd4);

    // R10 display table
    foreach (DV[i]) begin
      cpu_wr(1, {4'h8, DV[i][11:8]});
      cpu_wr(0, DV[i][7:0]);
    end
    foreach (DV[i]) begin
      cpu_wr(1, {4'h6, DV[i][11:8]});
      cpu_rd(0, d);
      chk(d == DV[i][7:0], "R10 readback", d, DV[i][7:0]);
      wait_scan(DV[i][11:8]);
      chk({grp_a, grp_b} == DV[i][7:0], "R10 groups", {grp_a, grp_b}, DV[i][7:0]);
    end
    // R10 auto increment
    cpu_wr(1, 8'h88);
    cpu_wr(0, 8'h11);
    cpu_wr(0, 8'h22);
    cpu_wr(1, 8'h68);
    cpu_rd(0, d); chk(d == 8'h11, "R10 incr", d, 8'h11);
    cpu_rd(0, d); chk(d == 8'h22, "R10 incr", d, 8'h22);
    cpu_wr(1, 8'h40);

    // R11 blanking
    cpu_wr(1, 8'hA1);
    wait_scan(4'd0);
    chk({grp_a, grp_b} == 8'h00, "R11 blank", {grp_a, grp_b}, 8'h00);
    cpu_wr(1, 8'hA0);
    wait_scan(4'd0);
    chk({grp_a, grp_b} == 8'h3C, "R11 unblank", {grp_a, grp_b}, 8'h3C);

    // R13 prescale change
    cpu_wr(1, 8'h27);
    wait_change(n);
    wait_change(n);
    chk(n == 8, "R13 period div7", n[7:0], 8'd8);
    cpu_wr(1, 8'h23);
    idle(20);

    // R3 single-visit closure
    wait_scan(4'd3);
    km[3] = 8'h10;
    do @(negedge clk); while (scan_out == 4'd3);
    km[3] = 8'h00;
    idle(200);
    cpu_rd(1, d);
    chk(d == 8'h00, "R3 glitch ignored", d, 8'h00);

    // R4 / R12 shift captured, long hold gives one entry
    shift_in = 1;
    km[5] = 8'h40;
    idle(300);
    km[5] = 8'h00; shift_in = 0;
    idle(200);
    cpu_rd(1, d);
    chk(d == 8'h01, "R12 one entry", d, 8'h01);
    chk(irq == 1'b1, "R6 irq high", {7'h0, irq}, 8'h01);
    cpu_rd(0, d);
    chk(d == 8'h6E, "R4 shift code", d, 8'h6E);
    ctrl_in = 1;
    km[0] = 8'h08;
    idle(300);
    cpu_rd(0, d);
    chk(d == 8'h83, "R4 ctrl code", d, 8'h83);
    km[0] = 8'h00; ctrl_in = 0;
    idle(200);
    chk(irq == 1'b0, "R6 irq low", {7'h0, irq}, 8'h00);

    // R8 lockout across rows
    km[1] = 8'h04;
    idle(300);
    km[3] = 8'h10;
    idle(300);
    cpu_rd(1, d);
    chk(d == 8'h01, "R8 second blocked", d, 8'h01);
    km[1] = 8'h00;
    idle(300);
    cpu_rd(1, d);
    chk(d == 8'h02, "R8 taken after release", d, 8'h02);
    cpu_rd(0, d); chk(d == 8'h0A, "R8 first code", d, 8'h0A);
    cpu_rd(0, d); chk(d == 8'h1C, "R8 second code", d, 8'h1C);
    km[3] = 8'h00;
    idle(200);

    // R8 lockout within one row
    wait_scan(4'd9);
    km[4] = 8'h42;
    idle(300);
    cpu_rd(1, d);
    chk(d == 8'h01, "R8 same row", d, 8'h01);
    cpu_rd(0, d); chk(d == 8'h21, "R8 lowest column", d, 8'h21);
    km[4] = 8'h00;
    idle(200);

    // R9 rollover
    cpu_wr(1, 8'h01);
    wait_scan(4'd9);
    km[4] = 8'h42; km[6] = 8'h01;
    idle(400);
    cpu_rd(1, d);
    chk(d == 8'h03, "R9 all queued", d, 8'h03);
    cpu_rd(0, d); chk(d == 8'h21, "R9 order", d, 8'h21);
    cpu_rd(0, d); chk(d == 8'h30, "R9 order", d, 8'h30);
    cpu_rd(0, d); chk(d == 8'h26, "R9 order", d, 8'h26);
    km[4] = 8'h00; km[6] = 8'h00;
    idle(200);

    // R7 / R5 overflow and order
    wait_scan(4'd9);
    km[0] = 8'hFF; km[1] = 8'h01;
    idle(900);
    cpu_rd(1, d);
    chk(d == 8'h88, "R7 full with overrun", d, 8'h88);
    cpu_wr(1, 8'hC0);
    cpu_rd(1, d);
    chk(d == 8'h08, "R7 overrun cleared", d, 8'h08);
    for (int i = 0; i < 8; i++) cpu_rd(0, q[i]);
    chk(q[0] == 8'h00, "R5 first", q[0], 8'h00);
    chk(q[1] == 8'h08, "R5 second", q[1], 8'h08);
    chk(q[7] == 8'h06, "R5 last kept", q[7], 8'h06);
    idle(2);
    chk(irq == 1'b0, "R6 drained", {7'h0, irq}, 8'h00);
    km[0] = 8'h00; km[1] = 8'h00;
    idle(200);
    cpu_wr(1, 8'h00);

    // R2 decoded sequence, R4 decoded row
    cpu_wr(1, 8'h02);
    tb_dec = 1'b1;
    wait_scan(4'b0001);
    wait_change(n); chk(scan_out == 4'b0010, "R2 decoded", {4'h0, scan_out}, 8'h02);
    wait_change(n); chk(scan_out == 4'b0100, "R2 decoded", {4'h0, scan_out}, 8'h04);
    wait_change(n); chk(scan_out == 4'b1000, "R2 decoded", {4'h0, scan_out}, 8'h08);
    wait_change(n); chk(scan_out == 4'b0001, "R2 decoded wrap", {4'h0, scan_out}, 8'h01);
    km[2] = 8'h02;
    idle(200);
    cpu_rd(0, d);
    chk(d == 8'h11, "R4 decoded row code", d, 8'h11);
    km[2] = 8'h00;
    idle(100);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule